// File: doc/BRIEF.md
# Deferred Page Write Buffer with Timed Programming

This block sits between a serial-memory protocol engine and a nonvolatile array model. During a write transaction, the protocol engine first hands over the starting byte address. It then streams data bytes, which the block gathers into a page buffer of one row (64 bytes by default). The row part of the address stays fixed for the whole transaction. Only the in-page offset advances, and it wraps inside the row. Each stored byte sets a per-offset dirty mark. Only marked offsets reach the array, so the rest of the row keeps its old contents.

Nothing is written while bytes arrive. A STOP that ends a transaction with at least one stored byte starts a self-timed programming interval of a fixed number of clocks, set by a parameter. During that interval a sequencer walks the page from offset 0 upward and issues one array write strobe per dirty offset. For the whole interval the block raises `busy_o`, and it ignores every input: bytes, address loads, START and STOP. A START, or a STOP with nothing stored, drops the buffer contents without programming. Bytes that arrive while the latched write-protect flag is high are consumed but never stored. A single-byte write is simply a page write with one byte.

Top module: `pgbuf_commit`

## Requirements
- R1: After reset, `busy_o` is 0, `byte_ready_o` is 1 and `arr_we_o` is 0.
- R2: A byte is taken on a clock edge where `byte_valid_i` and `byte_ready_o` are both 1. `byte_ready_o` equals the inverse of `busy_o`. While it is 0, the producer must hold its byte and the byte is not consumed.
- R3: On an address load, the row becomes `addr_i[ADDR_W-1:PAGE_BITS]` and the offset becomes `addr_i[PAGE_BITS-1:0]`. Each taken byte advances the offset modulo 2^PAGE_BITS and leaves the row unchanged. A byte taken again at a wrapped offset replaces the earlier byte there.
- R4: Programming writes exactly the offsets that received a byte since the last address load. Each is written once, with `arr_addr_o` = {row, offset} and the last byte stored at that offset.
- R5: A STOP with at least one stored byte raises `busy_o` on the next clock edge. `busy_o` then stays high for exactly PROG_CYCLES cycles.
- R6: A START at any time outside programming, or a STOP when no byte is stored, discards the buffer. No programming interval follows, and a later STOP without new bytes also starts none.
- R7: A byte taken while `wp_i` is 1 advances the offset but is neither stored nor marked. If only protected bytes were sent, STOP starts no programming.
- R8: While `busy_o` is 1, `addr_load_i`, `start_i`, `stop_i` and `byte_valid_i` have no effect on the buffer or on the timer.
- R9: Array writes appear only while `busy_o` is 1, in strictly ascending offset order, and all of them within the first 2^PAGE_BITS cycles of the interval. PROG_CYCLES must exceed 2^PAGE_BITS.
- R10: A transaction with a single data byte produces exactly one array write followed by a full programming interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse for a bus START |
| addr_load_i | input | 1 | One-cycle pulse loading the start address |
| addr_i | input | ADDR_W | Starting byte address |
| wp_i | input | 1 | Write-protect flag latched by the protocol engine |
| byte_valid_i | input | 1 | Data byte valid |
| byte_data_i | input | DATA_W | Data byte |
| byte_ready_o | output | 1 | Block can take a byte (low while programming) |
| stop_i | input | 1 | One-cycle pulse for a bus STOP |
| busy_o | output | 1 | Programming interval in progress; bus must be ignored |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |

## Verification
The checker assumes three things about the inputs. STOP is a single-cycle pulse. PROG_CYCLES is larger than the page size, so the ascending walk always finishes inside the busy window. Writes in one window never change row, because address loads are gated off while busy. The bench drives every pulse for exactly one cycle, away from the active edge, and uses an interval of 80 cycles against a 64-byte page. It also pulses the control inputs and offers a byte during programming, which exercises the ignore behaviour without breaking those assumptions.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  localparam int unsigned DEF_ADDR_W    = 15;
  localparam int unsigned DEF_DATA_W    = 8;
  localparam int unsigned DEF_PAGE_BITS = 6;
  localparam int unsigned DEF_PROG      = 200;
endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PAGE_BITS = 6,
  parameter int unsigned ROW_W     = 9,
  localparam int unsigned PAGE     = 1 << PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [ROW_W-1:0]     load_row_i,
  input  logic [PAGE_BITS-1:0] load_off_i,
  input  logic                 clear_i,
  input  logic                 put_i,
  input  logic                 keep_i,
  input  logic [DATA_W-1:0]    put_data_i,
  input  logic                 retire_i,
  input  logic [PAGE_BITS-1:0] rd_idx_i,
  output logic [ROW_W-1:0]     row_o,
  output logic [PAGE-1:0]      dirty_o,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 any_dirty_o
);
  logic [PAGE_BITS-1:0] ptr_q;
  logic [ROW_W-1:0]     row_q;
  logic [PAGE-1:0]      dirty_q;
  logic [DATA_W-1:0]    mem_q [PAGE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      row_q   <= '0;
      dirty_q <= '0;
    end else if (load_i) begin
      ptr_q   <= load_off_i;
      row_q   <= load_row_i;
      dirty_q <= '0;
    end else begin
      if (clear_i) begin
        dirty_q <= '0;
      end else begin
        if (put_i && keep_i) dirty_q[ptr_q] <= 1'b1;
        if (retire_i)        dirty_q[rd_idx_i] <= 1'b0;
      end
      if (put_i) ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (put_i && keep_i) mem_q[ptr_q] <= put_data_i;
  end

  assign row_o       = row_q;
  assign dirty_o     = dirty_q;
  assign rd_data_o   = mem_q[rd_idx_i];
  assign any_dirty_o = |dirty_q;
endmodule

// File: rtl/pgbuf_timer.sv
module pgbuf_timer #(
  parameter int unsigned PROG_CYCLES = 200,
  localparam int unsigned CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic busy_o
);
  logic [CW-1:0] tmr_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (fire_i) begin
        busy_q <= 1'b1;
        tmr_q  <= CW'(PROG_CYCLES - 1);
      end
    end else if (tmr_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      tmr_q <= tmr_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/pgbuf_seq.sv
module pgbuf_seq #(
  parameter int unsigned PAGE_BITS = 6,
  localparam int unsigned PAGE     = 1 << PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go_i,
  input  logic [PAGE-1:0]      dirty_i,
  output logic [PAGE_BITS-1:0] idx_o,
  output logic                 we_o
);
  logic                 active_q;
  logic [PAGE_BITS-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (go_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q) begin
      if (&idx_q) active_q <= 1'b0;
      else        idx_q    <= idx_q + 1'b1;
    end
  end

  assign idx_o = idx_q;
  assign we_o  = active_q && dirty_i[idx_q];
endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit
  import pgbuf_pkg::*;
#(
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned PAGE_BITS   = DEF_PAGE_BITS,
  parameter int unsigned PROG_CYCLES = DEF_PROG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_data_i,
  output logic              byte_ready_o,
  input  logic              stop_i,
  output logic              busy_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o
);
  localparam int unsigned ROW_W = ADDR_W - PAGE_BITS;
  localparam int unsigned PAGE  = 1 << PAGE_BITS;

  logic                 busy;
  logic                 any_dirty;
  logic [PAGE-1:0]      dirty;
  logic [ROW_W-1:0]     row;
  logic [PAGE_BITS-1:0] scan_idx;
  logic [DATA_W-1:0]    scan_data;
  logic                 scan_we;
  logic                 take, go, discard, load;

  assign take    = byte_valid_i && !busy;
  assign load    = addr_load_i && !busy;
  assign go      = stop_i && !busy && any_dirty;
  assign discard = !busy && (start_i || (stop_i && !any_dirty));

  pgbuf_store #(.DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS), .ROW_W(ROW_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .load_i(load), .load_row_i(addr_i[ADDR_W-1:PAGE_BITS]),
    .load_off_i(addr_i[PAGE_BITS-1:0]),
    .clear_i(discard), .put_i(take), .keep_i(!wp_i), .put_data_i(byte_data_i),
    .retire_i(scan_we), .rd_idx_i(scan_idx),
    .row_o(row), .dirty_o(dirty), .rd_data_o(scan_data), .any_dirty_o(any_dirty)
  );

  pgbuf_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .fire_i(go), .busy_o(busy)
  );

  pgbuf_seq #(.PAGE_BITS(PAGE_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_i(go), .dirty_i(dirty),
    .idx_o(scan_idx), .we_o(scan_we)
  );

  assign busy_o       = busy;
  assign byte_ready_o = !busy;
  assign arr_we_o     = scan_we;
  assign arr_addr_o   = {row, scan_idx};
  assign arr_data_o   = scan_data;
endmodule

// File: rtl/pgbuf_commit_chk.sv
module pgbuf_commit_chk #(
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned PAGE_BITS   = 6,
  parameter int unsigned PROG_CYCLES = 200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_i,
  input logic              byte_ready_o,
  input logic              busy_o,
  input logic              arr_we_o,
  input logic [ADDR_W-1:0] arr_addr_o
);
  localparam int unsigned ROW_W = ADDR_W - PAGE_BITS;

  int unsigned          len_q;
  int unsigned          win_q;
  logic                 seen_q;
  logic [PAGE_BITS-1:0] last_off_q;
  logic [ROW_W-1:0]     last_row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q      <= 0;
      win_q      <= 0;
      seen_q     <= 1'b0;
      last_off_q <= '0;
      last_row_q <= '0;
    end else begin
      len_q <= busy_o ? len_q + 1 : 0;
      win_q <= busy_o ? win_q + 1 : 0;
      if (!busy_o) begin
        seen_q <= 1'b0;
      end else if (arr_we_o) begin
        seen_q     <= 1'b1;
        last_off_q <= arr_addr_o[PAGE_BITS-1:0];
        last_row_q <= arr_addr_o[ADDR_W-1:PAGE_BITS];
      end
    end
  end

  a_r2_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !byte_ready_o);
  a_r5_rise_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));
  a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (len_q == PROG_CYCLES));
  a_r9_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> busy_o);
  a_r9_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we_o && seen_q) |-> (arr_addr_o[PAGE_BITS-1:0] > last_off_q));
  a_r9_early_window: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> (win_q < (1 << PAGE_BITS)));
  a_r3_row_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we_o && seen_q) |-> (arr_addr_o[ADDR_W-1:PAGE_BITS] == last_row_q));
endmodule

bind pgbuf_commit pgbuf_commit_chk #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .byte_ready_o(byte_ready_o),
  .busy_o(busy_o), .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o)
);

// File: tb/sim_pgbuf_commit.sv
`timescale 1ns/1ps
module sim_pgbuf_commit;
  localparam int AW = 15;
  localparam int DW = 8;
  localparam int PB = 6;
  localparam int PG = 1 << PB;
  localparam int PROG = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, addr_load_i = 0, wp_i = 0, byte_valid_i = 0, stop_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] byte_data_i = '0;
  logic byte_ready_o, busy_o, arr_we_o;
  logic [AW-1:0] arr_addr_o;
  logic [DW-1:0] arr_data_o;

  int checks = 0;
  int errors = 0;
  bit exp_v [PG];
  logic [DW-1:0] exp_d [PG];
  int cap_a [$];
  int cap_d [$];

  always #10 clk = ~clk;

  pgbuf_commit #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(PB), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_load_i(addr_load_i),
    .addr_i(addr_i), .wp_i(wp_i), .byte_valid_i(byte_valid_i),
    .byte_data_i(byte_data_i), .byte_ready_o(byte_ready_o), .stop_i(stop_i),
    .busy_o(busy_o), .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o),
    .arr_data_o(arr_data_o));

  always @(negedge clk) if (rst_n && arr_we_o) begin
    cap_a.push_back(int'(arr_addr_o));
    cap_d.push_back(int'(arr_data_o));
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr_exp();
    for (int i = 0; i < PG; i++) begin exp_v[i] = 0; exp_d[i] = '0; end
    cap_a.delete(); cap_d.delete();
  endtask

  task automatic do_load(input int a);
    addr_i = AW'(a); addr_load_i = 1; @(negedge clk); addr_load_i = 0;
  endtask
  task automatic do_byte(input int d);
    byte_valid_i = 1; byte_data_i = DW'(d); @(negedge clk); byte_valid_i = 0;
  endtask
  task automatic do_stop();
    stop_i = 1; @(negedge clk); stop_i = 0;
  endtask
  task automatic do_start();
    start_i = 1; @(negedge clk); start_i = 0;
  endtask

  // Called right after do_stop; expects a programming interval.
  task automatic wait_commit(input string req, input int row);
    int n = 0;
    int k = 0;
    while (busy_o && n < 10 * PROG) begin n++; @(negedge clk); end
    chk(n == PROG, "R5", "busy length", n, PROG);
    for (int i = 0; i < PG; i++) if (exp_v[i]) begin
      if (k < cap_a.size()) begin
        chk(cap_a[k] == ((row << PB) | i), req, "write addr", cap_a[k], (row << PB) | i);
        chk(cap_d[k] == int'(exp_d[i]), req, "write data", cap_d[k], int'(exp_d[i]));
      end
      k++;
    end
    chk(cap_a.size() == k, req, "write count", cap_a.size(), k);
  endtask

  task automatic expect_idle(input string req);
    repeat (3) begin
      chk(busy_o == 0, req, "busy stays low", int'(busy_o), 0);
      @(negedge clk);
    end
    chk(cap_a.size() == 0, req, "no array write", cap_a.size(), 0);
  endtask

  task automatic t_reset();
    chk(busy_o == 0, "R1", "busy after reset", int'(busy_o), 0);
    chk(byte_ready_o == 1, "R1", "ready after reset", int'(byte_ready_o), 1);
    chk(arr_we_o == 0, "R1", "we after reset", int'(arr_we_o), 0);
  endtask

  task automatic t_single();  // R10 single byte write
    clr_exp();
    do_load(16'h1234 & 16'h7FFF);
    do_byte(8'hA5); exp_v[6'h34] = 1; exp_d[6'h34] = 8'hA5;
    do_stop();
    chk(busy_o == 1, "R5", "busy after stop", int'(busy_o), 1);
    wait_commit("R10", 16'h1234 >> PB);
  endtask

  task automatic t_wrap_partial();  // R3 wrap from offset 60, R4 sparse
    int row = 9'h155;
    clr_exp();
    do_load((row << PB) | 60);
    for (int i = 0; i < 8; i++) begin
      do_byte(8'h10 + i); exp_v[(60 + i) % PG] = 1; exp_d[(60 + i) % PG] = DW'(8'h10 + i);
    end
    do_stop();
    wait_commit("R3", row);
    chk(cap_a.size() > 0 && cap_a[0] == (row << PB), "R9", "first write offset 0",
        cap_a.size() > 0 ? cap_a[0] : -1, row << PB);
  endtask

  task automatic t_overwrite();  // R3 overwrite, R4 full page
    int row = 3;
    clr_exp();
    do_load(row << PB);
    for (int i = 0; i < PG + 2; i++) begin
      do_byte(i ^ 8'h5A); exp_v[i % PG] = 1; exp_d[i % PG] = DW'(i ^ 8'h5A);
    end
    do_stop();
    wait_commit("R4", row);
  endtask

  task automatic t_protect();
    clr_exp();
    wp_i = 1;
    do_load(16'h0200);
    do_byte(8'h11); do_byte(8'h22);
    do_stop();
    wp_i = 0;
    expect_idle("R7");
  endtask

  task automatic t_empty_stop();
    clr_exp();
    do_load(16'h0440);
    do_stop();
    expect_idle("R6");
  endtask

  task automatic t_start_discard();
    clr_exp();
    do_load(16'h0480);
    do_byte(8'h33); do_byte(8'h44);
    do_start();
    do_stop();
    expect_idle("R6");
  endtask

  task automatic t_deaf();  // R8 inputs ignored while busy, R2 back-pressure
    int row = 2;
    clr_exp();
    do_load(row << PB);
    do_byte(8'hC1); exp_v[0] = 1; exp_d[0] = 8'hC1;
    do_byte(8'hC2); exp_v[1] = 1; exp_d[1] = 8'hC2;
    do_stop();
    chk(byte_ready_o == 0, "R2", "ready low while busy", int'(byte_ready_o), 0);
    addr_i = AW'(16'h7FC0); addr_load_i = 1; byte_valid_i = 1; byte_data_i = 8'hEE;
    start_i = 1; stop_i = 1;
    @(negedge clk);
    addr_load_i = 0; byte_valid_i = 0; start_i = 0; stop_i = 0;
    begin
      int n = 1;
      while (busy_o && n < 10 * PROG) begin n++; @(negedge clk); end
      chk(n == PROG, "R8", "busy length unchanged", n, PROG);
    end
    chk(cap_a.size() == 2, "R8", "only original writes", cap_a.size(), 2);
    if (cap_a.size() == 2) begin
      chk(cap_a[1] == ((row << PB) | 1), "R8", "row kept", cap_a[1], (row << PB) | 1);
      chk(cap_d[1] == 8'hC2, "R8", "data kept", cap_d[1], 8'hC2);
    end
    clr_exp();
    do_stop();
    expect_idle("R8");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_wrap_partial();
    t_overwrite();
    t_protect();
    t_empty_stop();
    t_start_discard();
    t_deaf();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule